// File: doc/BRIEF.md
# Programmable Horizontal and Vertical Sync Pulse Timer

This block turns decoded timing strobes into the two sync outputs of a video pixel port. A line-start strobe is delayed by a fixed pipeline latency and then starts an active-low horizontal sync pulse. The pulse width is taken from an 8-bit end value and counts two clock cycles per step, so it spans 0 to 510 cycles.

The vertical sync output goes low one cycle after a strobe marking the middle of the first serration pulse. Its release depends on the field. On an odd field it is released a fixed gap after the trailing edge of the first horizontal pulse that begins after the last-equalisation strobe. On an even field it is released the same gap before the leading edge of the next horizontal pulse. That edge is predicted from the measured spacing of the two most recent horizontal leading edges.

Both outputs are registered. They stay inactive after reset until the first line start.

Top module: `hvs_sync_timer`

## Requirements
- R1: After reset both outputs are high, and they stay high until the first line_start, even if serr_mid or last_eq pulse in the meantime.
- R2: When line_start is sampled at clock edge k, hsync_n goes low after edge k+LAT (LAT defaults to 16).
- R3: hs_end is sampled at the leading edge, and hsync_n stays low for exactly 2*hs_end cycles. A value of 0 produces no pulse.
- R4: A serr_mid strobe sampled after the first line_start drives vsync_n low after the same edge. It also cancels any pending release.
- R5: When last_eq is sampled with field_odd=1, vsync_n goes high exactly VS_GAP (default 5) cycles after hsync_n rises at the end of the first horizontal pulse whose leading edge comes after that strobe.
- R6: When last_eq is sampled with field_odd=0, vsync_n goes high exactly VS_GAP cycles before the next hsync_n falling edge. That edge is predicted as the previous leading edge plus the spacing measured between the two most recent leading edges.
- R7: On an odd field with hs_end=0, the trailing edge coincides with the leading edge. vsync_n then goes high VS_GAP cycles after the cycle in which the pulse would have started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock (twice the sample rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at each detected line start |
| serr_mid | input | 1 | One-cycle strobe at the middle of the first serration pulse |
| last_eq | input | 1 | One-cycle strobe at the last equalisation pulse |
| field_odd | input | 1 | 1 for an odd field, sampled with last_eq |
| hs_end | input | 8 | Horizontal pulse width in units of two cycles |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync |

## Verification
The bench builds the block with LAT=4 and LINE_W=10 and keeps the default VS_GAP of 5. The short latency lets a line of 40 cycles hold both the delayed leading edge and the vertical release window. Ten bits of line counter still leave room for the longest 510-cycle pulse. Two line periods, 40 and 56 cycles, show that the even-field release follows the measured spacing rather than a fixed one.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
  localparam int HS_END_W = 8;
  localparam int HS_CNT_W = HS_END_W + 1;

  typedef logic [HS_END_W-1:0] hs_end_t;
  typedef logic [HS_CNT_W-1:0] hs_cnt_t;

  // pulse width in clock cycles: two cycles per step of the end value
  function automatic hs_cnt_t hs_width(input hs_end_t e);
    return {e, 1'b0};
  endfunction
endpackage

// File: rtl/hvs_line_delay.sv
module hvs_line_delay #(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  output logic lead_evt
);
  logic [LAT-1:0] sh;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= line_start;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAT-2:0], line_start};
      end
    end
  endgenerate

  assign lead_evt = sh[LAT-1];
endmodule

// File: rtl/hvs_line_meter.sv
module hvs_line_meter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_evt,
  output logic [LINE_W-1:0] lead_phase,
  output logic [LINE_W-1:0] line_len,
  output logic              len_valid
);
  localparam logic [LINE_W-1:0] PH_MAX = '1;
  logic got_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_phase <= '0;
      line_len   <= '0;
      len_valid  <= 1'b0;
      got_one    <= 1'b0;
    end else if (lead_evt) begin
      line_len   <= lead_phase + 1'b1;
      len_valid  <= got_one;
      got_one    <= 1'b1;
      lead_phase <= '0;
    end else if (lead_phase != PH_MAX) begin
      lead_phase <= lead_phase + 1'b1;
    end
  end

  // R6: the measured spacing is never zero once valid
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> line_len != '0);
endmodule

// File: rtl/hvs_hpulse.sv
module hvs_hpulse
  import hvs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lead_evt,
  input  hs_end_t hs_end,
  output logic    hsync_n,
  output logic    trail_evt
);
  hs_cnt_t hcnt;
  hs_cnt_t width;

  assign width     = hs_width(hs_end);
  assign trail_evt = lead_evt ? (width == '0) : (hcnt == hs_cnt_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt    <= '0;
      hsync_n <= 1'b1;
    end else if (lead_evt) begin
      hcnt    <= width;
      hsync_n <= (width == '0);
    end else if (hcnt != '0) begin
      hcnt    <= hcnt - 1'b1;
      hsync_n <= (hcnt == hs_cnt_t'(1));
    end
  end

  // R3
  hs_lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_evt && hs_end != '0) |=> !hsync_n);
  // R3
  hs_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> $past(trail_evt));
endmodule

// File: rtl/hvs_vpulse.sv
module hvs_vpulse #(
  parameter int LINE_W = 12,
  parameter int VS_GAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              serr_evt,
  input  logic              eq_evt,
  input  logic              field_odd,
  input  logic              lead_evt,
  input  logic              trail_evt,
  input  logic [LINE_W-1:0] lead_phase,
  input  logic [LINE_W-1:0] line_len,
  input  logic              len_valid,
  output logic              vsync_n
);
  localparam int OC_W = $clog2(VS_GAP + 1);
  localparam logic [LINE_W:0] GAP_P1 = (LINE_W+1)'(VS_GAP + 1);

  logic            pend_even, pend_odd, odd_wait;
  logic [OC_W-1:0] ocnt;
  logic            serr_fire, odd_go, end_odd, end_even;
  logic [LINE_W:0] ph_ahead;

  assign serr_fire = armed & serr_evt;
  assign odd_go    = trail_evt & (odd_wait | (pend_odd & lead_evt));
  assign end_odd   = (ocnt == OC_W'(1));
  assign ph_ahead  = {1'b0, lead_phase} + GAP_P1;
  assign end_even  = pend_even & len_valid & (ph_ahead == {1'b0, line_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsync_n   <= 1'b1;
      pend_even <= 1'b0;
      pend_odd  <= 1'b0;
      odd_wait  <= 1'b0;
      ocnt      <= '0;
    end else if (serr_fire) begin
      vsync_n   <= 1'b0;
      pend_even <= 1'b0;
      pend_odd  <= 1'b0;
      odd_wait  <= 1'b0;
      ocnt      <= '0;
    end else begin
      if (end_odd || end_even) vsync_n <= 1'b1;
      pend_even <= (pend_even & ~end_even) | (eq_evt & ~field_odd);
      pend_odd  <= (pend_odd & ~lead_evt) | (eq_evt & field_odd);
      odd_wait  <= (odd_wait | (pend_odd & lead_evt)) & ~trail_evt;
      if (odd_go)          ocnt <= OC_W'(VS_GAP);
      else if (ocnt != '0) ocnt <= ocnt - 1'b1;
    end
  end

  // R4
  vs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_fire |=> !vsync_n);
  // R5
  vs_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> $past(end_odd || end_even));
  // R5
  odd_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt <= OC_W'(VS_GAP));
endmodule

// File: rtl/hvs_sync_timer.sv
module hvs_sync_timer
  import hvs_pkg::*;
#(
  parameter int LAT    = 16,
  parameter int LINE_W = 12,
  parameter int VS_GAP = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       serr_mid,
  input  logic       last_eq,
  input  logic       field_odd,
  input  logic [7:0] hs_end,
  output logic       hsync_n,
  output logic       vsync_n
);
  logic              seen_line;
  logic              lead_evt, trail_evt;
  logic [LINE_W-1:0] lead_phase, line_len;
  logic              len_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)          seen_line <= 1'b0;
    else if (line_start) seen_line <= 1'b1;
  end

  hvs_line_delay #(.LAT(LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .lead_evt(lead_evt)
  );

  hvs_line_meter #(.LINE_W(LINE_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .lead_evt(lead_evt),
    .lead_phase(lead_phase), .line_len(line_len), .len_valid(len_valid)
  );

  hvs_hpulse u_hpulse (
    .clk(clk), .rst_n(rst_n), .lead_evt(lead_evt), .hs_end(hs_end_t'(hs_end)),
    .hsync_n(hsync_n), .trail_evt(trail_evt)
  );

  hvs_vpulse #(.LINE_W(LINE_W), .VS_GAP(VS_GAP)) u_vpulse (
    .clk(clk), .rst_n(rst_n), .armed(seen_line), .serr_evt(serr_mid),
    .eq_evt(last_eq), .field_odd(field_odd), .lead_evt(lead_evt),
    .trail_evt(trail_evt), .lead_phase(lead_phase), .line_len(line_len),
    .len_valid(len_valid), .vsync_n(vsync_n)
  );

  // R1
  idle_before_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_line |-> (hsync_n && vsync_n));
endmodule

// File: tb/hvs_sync_timer_tb.sv
module hvs_sync_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int LINE_W = 10;
  localparam int GAP = 5;
  localparam int NV = 5;
  // {hs_end, expected low cycles}
  localparam int TBL [NV][2] = '{'{1, 2}, '{3, 6}, '{7, 14}, '{0, 0}, '{255, 510}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, serr_mid = 1'b0, last_eq = 1'b0, field_odd = 1'b0;
  logic [7:0] hs_end = '0;
  logic hsync_n, vsync_n;

  int total = 0, failed = 0;
  int cyc = 0;
  int last_ls = 0;
  int per = 40;
  bit gen_on = 1'b0;

  hvs_sync_timer #(.LAT(LAT), .LINE_W(LINE_W), .VS_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .serr_mid(serr_mid),
    .last_eq(last_eq), .field_odd(field_odd), .hs_end(hs_end),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_serr();
    serr_mid = 1'b1; tick(); serr_mid = 1'b0;
  endtask

  task automatic pulse_eq(input bit odd);
    field_odd = odd; last_eq = 1'b1; tick(); last_eq = 1'b0;
  endtask

  // vr: vsync rise; hr: last hsync rise before vr; hf: first hsync fall after vr
  task automatic watch(input int n, output int vr, output int hr, output int hf, output int ls);
    bit pv, ph;
    vr = -1; hr = -1; hf = -1; ls = -1;
    pv = vsync_n; ph = hsync_n;
    repeat (n) begin
      tick();
      if (!ph && hsync_n && vr < 0) hr = cyc;
      if (!pv && vsync_n && vr < 0) begin vr = cyc; ls = last_ls; end
      if (ph && !hsync_n && vr >= 0 && hf < 0 && cyc > vr) hf = cyc;
      pv = vsync_n; ph = hsync_n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int gcnt;
    gcnt = 0;
    forever begin
      tick();
      if (gen_on) begin
        if (gcnt >= per - 1) begin
          line_start = 1'b1; gcnt = 0; last_ls = cyc + 1;
        end else begin
          line_start = 1'b0; gcnt++;
        end
      end
    end
  end

  initial begin
    int d, w, vr, hr, hf, ls;
    repeat (3) tick();
    chk(hsync_n == 1'b1, "R1 hsync_n in reset", hsync_n, 1);
    chk(vsync_n == 1'b1, "R1 vsync_n in reset", vsync_n, 1);
    rst_n = 1'b1;
    tick();
    // R1: sync strobes before any line start are ignored
    pulse_serr();
    pulse_eq(1'b1);
    repeat (8) tick();
    chk(vsync_n == 1'b1, "R1 vsync_n idle before line", vsync_n, 1);
    chk(hsync_n == 1'b1, "R1 hsync_n idle before line", hsync_n, 1);

    // R2/R3 table of widths
    for (int i = 0; i < NV; i++) begin
      hs_end = 8'(TBL[i][0]);
      line_start = 1'b1; tick(); line_start = 1'b0;
      d = 0;
      while (hsync_n && d < LAT + 6) begin tick(); d++; end
      if (TBL[i][1] == 0) begin
        chk(hsync_n == 1'b1, "R3 zero width gives no pulse", hsync_n, 1);
      end else begin
        chk(d == LAT, "R2 leading edge latency", d, LAT);
        w = 0;
        while (!hsync_n && w < 600) begin tick(); w++; end
        chk(w == TBL[i][1], "R3 pulse width", w, TBL[i][1]);
      end
      repeat (5) tick();
    end

    // periodic lines
    hs_end = 8'd4; per = 40; gen_on = 1'b1;
    repeat (120) tick();
    chk(vsync_n == 1'b1, "R4 vsync_n high before serration", vsync_n, 1);
    pulse_serr();
    chk(vsync_n == 1'b0, "R4 vsync_n low after serration strobe", vsync_n, 0);

    pulse_eq(1'b0);
    watch(150, vr, hr, hf, ls);
    chk(vr >= 0 && hf >= 0, "R6 even release seen", vr, 0);
    chk(hf - vr == GAP, "R6 even release ahead of hsync", hf - vr, GAP);

    pulse_serr();
    chk(vsync_n == 1'b0, "R4 vsync_n low again", vsync_n, 0);
    pulse_eq(1'b1);
    watch(150, vr, hr, hf, ls);
    chk(vr >= 0 && hr >= 0, "R5 odd release seen", vr, 0);
    chk(vr - hr == GAP, "R5 odd release after hsync trailing edge", vr - hr, GAP);

    hs_end = 8'd0;
    repeat (50) tick();
    pulse_serr();
    pulse_eq(1'b1);
    watch(150, vr, hr, hf, ls);
    chk(vr == ls + LAT + GAP, "R7 odd release with zero width", vr, ls + LAT + GAP);

    hs_end = 8'd4; per = 56;
    repeat (160) tick();
    pulse_serr();
    pulse_eq(1'b0);
    watch(150, vr, hr, hf, ls);
    chk(vr >= 0 && hf >= 0, "R6 even release seen at longer line", vr, 0);
    chk(hf - vr == GAP, "R6 even release follows measured spacing", hf - vr, GAP);

    gen_on = 1'b0;
    line_start = 1'b0;
    repeat (4) tick();
    finish_run();
  end
endmodule